// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This engine measures how far apart two equally sized blocks of unsigned pixels are. It adds up the magnitude of the difference between each pair of pixels that share a position. Both blocks sit in external memories that are read combinationally. The engine drives one address to both memories at once and takes the two pixels back on separate data buses in the same cycle.

A one-cycle `go` pulse starts a pass. The engine clears its running total and its element index. It then alternates between a test cycle and an accumulate cycle for each element. The test cycle checks the index against the block depth. The accumulate cycle reads the pair, adds the magnitude of their difference to the total and advances the index. Once every element has been visited, the total is copied into a result register and `done` pulses for one cycle. The result register keeps that value until the next pass completes, so a consumer can read it at any time in between.

With the default configuration a block holds 256 pixels of 8 bits. The total is 32 bits wide and the index is 9 bits wide. One pass takes two cycles per element plus a fixed overhead.

Top module: `sad_engine`

## Requirements
- R1: During reset and in the first cycle after it, `sad` is 0 and both `done` and `rd_en` are 0.
- R2: While idle with `go` low, the engine issues no reads (`rd_en` stays 0), raises no `done` and leaves `sad` unchanged.
- R3: At the end of a pass, `sad` equals the sum over all indices k of |A[k] − B[k]|. Each pixel is taken as an unsigned 8-bit value, so each term lies in 0 to 255.
- R4: The sign of the difference is irrelevant. All-255 against all-0 and all-0 against all-255 both give 65280, and identical blocks give 0.
- R5: Each pass raises `rd_en` on exactly 256 cycles, never on two cycles in a row. The addresses on those cycles run from 0 to 255 in ascending order, one per element.
- R6: If `go` is sampled high by the idle engine at a clock edge, `done` is high exactly 2·256+3 cycles after that edge, and it stays high for exactly one cycle.
- R7: `sad` keeps the previous pass's result throughout a pass. It takes the new total on the clock edge that ends the `done` cycle.
- R8: Every pass starts from a cleared total and index, so a pass started right after another gives a result that depends only on the current memory contents.
- R9: Any activity on `go` while a pass is running has no effect on that pass's reads, latency or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Starts a pass when sampled high in idle |
| rd_addr | output | 8 | Address shared by both pixel memories |
| rd_en | output | 1 | High in the cycle a pixel pair is consumed |
| a_data | input | 8 | Pixel from the first block at `rd_addr` |
| b_data | input | 8 | Pixel from the second block at `rd_addr` |
| sad | output | 32 | Result of the last completed pass |
| done | output | 1 | One-cycle pulse in the final cycle of a pass |

## Verification
The sweeps include all-max against all-zero in both orders. A design that takes the difference as signed, or forgets to negate it, gives a wrong total in one of these orders. Single-element mismatches at index 0 and at index 255 show whether the loop bound is off by one, since such a design skips or repeats one of those pixels. Passes issued back to back, with different memory contents, show whether the total was cleared. The bench also watches `sad` in the middle of a pass, which catches a result register that follows the running total. It counts the latency and the order of the reads, which catches a controller that merges or repeats cycles. `go` is toggled during a pass to show that a busy engine ignores a restart.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_INIT   = 3'd1,
      ST_CHECK  = 3'd2,
      ST_ACCUM  = 3'd3,
      ST_FINISH = 3'd4
   } sad_state_e;

   // Absolute-difference implementation choices
   localparam int ABS_NEGATE  = 0;  // widened subtract, then conditional negate
   localparam int ABS_COMPARE = 1;  // compare, then subtract the smaller

endpackage

// File: rtl/sad_ctrl.sv
`timescale 1ns/1ps
module sad_ctrl
   import sad_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic idx_lt,
   output logic sum_clr,
   output logic sum_ld,
   output logic idx_clr,
   output logic idx_inc,
   output logic out_ld,
   output logic rd_en,
   output logic done
);

   sad_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (go) state_d = ST_INIT;
         ST_INIT:   state_d = ST_CHECK;
         ST_CHECK:  state_d = idx_lt ? ST_ACCUM : ST_FINISH;
         ST_ACCUM:  state_d = ST_CHECK;
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      sum_clr = (state_q == ST_INIT);
      idx_clr = (state_q == ST_INIT);
      sum_ld  = (state_q == ST_ACCUM);
      idx_inc = (state_q == ST_ACCUM);
      rd_en   = (state_q == ST_ACCUM);
      out_ld  = (state_q == ST_FINISH);
      done    = (state_q == ST_FINISH);
   end

   // R6: the completion pulse lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: reads are separated by a test cycle
   a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   // R2: idle with go low issues nothing
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !go) |=> (!rd_en && !done));

   // R9: a running pass never falls back to init on go
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACCUM) |=> (state_q == ST_CHECK));

endmodule

// File: rtl/sad_index.sv
`timescale 1ns/1ps
module sad_index #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int IDX_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic              lt_depth,
   output logic [ADDR_W-1:0] addr
);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx_q <= '0;
      else if (clr) idx_q <= '0;
      else if (inc) idx_q <= idx_q + IDX_W'(1);
   end

   assign lt_depth = (idx_q < IDX_W'(DEPTH));
   assign addr     = idx_q[ADDR_W-1:0];

   // R5: index never walks past the block depth
   a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(DEPTH));

   // R5: each increment advances by exactly one
   a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

   // R8: clearing returns the index to zero
   a_r8_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (idx_q == '0));

endmodule

// File: rtl/sad_accum.sv
`timescale 1ns/1ps
module sad_accum
   import sad_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int SUM_W     = 32,
   parameter int ABS_STYLE = ABS_NEGATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] a_pix,
   input  logic [PIX_W-1:0] b_pix,
   input  logic             sum_clr,
   input  logic             sum_ld,
   input  logic             out_ld,
   output logic [SUM_W-1:0] result
);

   localparam int DIFF_W = PIX_W + 1;

   logic [PIX_W-1:0] mag;
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] res_q;

   generate
      if (ABS_STYLE == ABS_NEGATE) begin : g_abs_neg
         logic [DIFF_W-1:0] diff;
         logic [DIFF_W-1:0] diff_neg;
         assign diff     = {1'b0, a_pix} - {1'b0, b_pix};
         assign diff_neg = (~diff) + DIFF_W'(1);
         assign mag      = diff[DIFF_W-1] ? diff_neg[PIX_W-1:0] : diff[PIX_W-1:0];
      end else begin : g_abs_cmp
         assign mag = (a_pix >= b_pix) ? (a_pix - b_pix) : (b_pix - a_pix);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sum_q <= '0;
      else if (sum_clr) sum_q <= '0;
      else if (sum_ld)  sum_q <= sum_q + {{(SUM_W-PIX_W){1'b0}}, mag};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (out_ld) res_q <= sum_q;
   end

   assign result = res_q;

   // R7: the result only moves when a pass finishes
   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ld |=> $stable(result));

   // R3: accumulation never wraps
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_ld && !sum_clr) |=> (sum_q >= $past(sum_q)));

   // R8: a pass starts from a cleared total
   a_r8_sum_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sum_clr |=> (sum_q == '0));

endmodule

// File: rtl/sad_engine.sv
`timescale 1ns/1ps
module sad_engine
   import sad_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int DEPTH     = 256,
   parameter int SUM_W     = 32,
   parameter int ABS_STYLE = ABS_NEGATE,
   localparam int ADDR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_en,
   input  logic [PIX_W-1:0]  a_data,
   input  logic [PIX_W-1:0]  b_data,
   output logic [SUM_W-1:0]  sad,
   output logic              done
);

   localparam int IDX_W = ADDR_W + 1;

   generate
      if (PIX_W < 1) begin : g_bad_pix
         $error("sad_engine: PIX_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sad_engine: DEPTH must be at least 2");
      end
      if (SUM_W < PIX_W + ADDR_W + 1) begin : g_bad_sum
         $error("sad_engine: SUM_W too narrow for DEPTH full-scale terms");
      end
      if (ABS_STYLE != ABS_NEGATE && ABS_STYLE != ABS_COMPARE) begin : g_bad_abs
         $error("sad_engine: unknown ABS_STYLE");
      end
   endgenerate

   logic sum_clr, sum_ld, idx_clr, idx_inc, out_ld, idx_lt;

   sad_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .idx_lt  (idx_lt),
      .sum_clr (sum_clr),
      .sum_ld  (sum_ld),
      .idx_clr (idx_clr),
      .idx_inc (idx_inc),
      .out_ld  (out_ld),
      .rd_en   (rd_en),
      .done    (done)
   );

   sad_index #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (idx_clr),
      .inc      (idx_inc),
      .lt_depth (idx_lt),
      .addr     (rd_addr)
   );

   sad_accum #(
      .PIX_W     (PIX_W),
      .SUM_W     (SUM_W),
      .ABS_STYLE (ABS_STYLE)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_pix   (a_data),
      .b_pix   (b_data),
      .sum_clr (sum_clr),
      .sum_ld  (sum_ld),
      .out_ld  (out_ld),
      .result  (sad)
   );

   // R1: reset leaves outputs quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (sad == '0 && !done && !rd_en));

endmodule

// File: tb/tb_sad_engine.sv
`timescale 1ns/1ps
module tb_sad_engine;

   localparam int PIX_W = 8;
   localparam int DEPTH = 256;
   localparam int SUM_W = 32;
   localparam int LAT   = 2 * DEPTH + 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             go = 1'b0;
   logic [7:0]       rd_addr;
   logic             rd_en;
   logic [PIX_W-1:0] a_data, b_data;
   logic [SUM_W-1:0] sad;
   logic             done;

   logic [PIX_W-1:0] mem_a [DEPTH];
   logic [PIX_W-1:0] mem_b [DEPTH];

   int n_checks = 0;
   int n_fail   = 0;
   int exp_addr = 0;
   int rd_cnt   = 0;
   int order_err = 0;
   int back_err  = 0;
   logic prev_rd = 1'b0;
   bit   finished = 1'b0;
   logic [SUM_W-1:0] prev_result = '0;

   always #2.5 clk = ~clk;

   assign a_data = mem_a[rd_addr];
   assign b_data = mem_b[rd_addr];

   sad_engine dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .rd_addr (rd_addr),
      .rd_en   (rd_en),
      .a_data  (a_data),
      .b_data  (b_data),
      .sad     (sad),
      .done    (done)
   );

   // read monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rd_en) begin
         if (int'(rd_addr) != exp_addr) order_err++;
         if (prev_rd) back_err++;
         exp_addr++;
         rd_cnt++;
      end
      prev_rd = rd_en;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint expected_sum();
      longint s = 0;
      for (int k = 0; k < DEPTH; k++) begin
         int d = int'(mem_a[k]) - int'(mem_b[k]);
         s += (d < 0) ? -d : d;
      end
      return s;
   endfunction

   task automatic fill(input int p);
      for (int k = 0; k < DEPTH; k++) begin
         case (p)
            0: begin mem_a[k] = 8'(k);             mem_b[k] = 8'(k);             end
            1: begin mem_a[k] = 8'hFF;             mem_b[k] = 8'h00;             end
            2: begin mem_a[k] = 8'h00;             mem_b[k] = 8'hFF;             end
            3: begin mem_a[k] = 8'(k);             mem_b[k] = 8'(255 - k);       end
            4: begin mem_a[k] = 8'(k * 73 + 19);   mem_b[k] = 8'((k * 151 + 7) ^ 90); end
            5: begin mem_a[k] = (k == DEPTH-1) ? 8'd200 : 8'd0; mem_b[k] = 8'd0; end
            6: begin mem_a[k] = (k == 0) ? 8'd0 : 8'(k ^ 33); mem_b[k] = (k == 0) ? 8'd255 : 8'(k ^ 33); end
            default: begin mem_a[k] = 8'((k * k + 5) >> 1); mem_b[k] = 8'(k * 29 + 200); end
         endcase
      end
   endtask

   task automatic run_pass(input string tag, input bit noisy_go);
      int cyc = 0;
      longint exp_s = expected_sum();
      exp_addr = 0; rd_cnt = 0; order_err = 0; back_err = 0;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      cyc = 1;
      while (!done && cyc < 4 * LAT) begin
         @(negedge clk);
         cyc++;
         go = noisy_go && (cyc > 10 && cyc < 40 || cyc == 200);
         if (cyc == 300)
            check(sad == prev_result, {"R7 result held mid-pass ", tag}, sad, prev_result);
      end
      go = 1'b0;
      check(cyc == LAT, {"R6 latency ", tag}, cyc, LAT);
      check(rd_cnt == DEPTH && order_err == 0 && back_err == 0,
            {"R5 read sequence ", tag}, rd_cnt + order_err + back_err, DEPTH);
      @(negedge clk);
      check(!done, {"R6 done single cycle ", tag}, done, 0);
      check(sad == exp_s, {"R3 result ", tag}, sad, exp_s);
      prev_result = sad;
   endtask

   initial begin
      for (int k = 0; k < DEPTH; k++) begin mem_a[k] = '0; mem_b[k] = '0; end
      repeat (3) @(negedge clk);
      check(sad == 0 && !done && !rd_en, "R1 outputs in reset", sad, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sad == 0 && !done && !rd_en, "R1 outputs after reset", sad, 0);

      // R2: idle with go low and changing memories
      fill(4);
      begin
         bit quiet = 1'b1;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_en || done || sad != 0) quiet = 1'b0;
         end
         check(quiet, "R2 idle stays quiet", sad, 0);
      end

      fill(0); run_pass("identical", 1'b0);
      check(sad == 0, "R4 identical blocks give zero", sad, 0);
      fill(1); run_pass("a max b zero", 1'b0);
      check(sad == 65280, "R4 a>b full scale", sad, 65280);
      fill(2); run_pass("a zero b max", 1'b0);
      check(sad == 65280, "R4 b>a full scale", sad, 65280);
      fill(3); run_pass("ramp vs reverse", 1'b0);
      fill(5); run_pass("last element only", 1'b0);
      check(sad == 200, "R3 last index included", sad, 200);
      fill(6); run_pass("first element only", 1'b0);
      check(sad == 255, "R3 first index included", sad, 255);
      // R8: back-to-back passes with new data
      fill(4); run_pass("R8 back-to-back 1", 1'b0);
      fill(7); run_pass("R8 back-to-back 2", 1'b0);
      // R9: go toggled during the pass
      fill(4); run_pass("R9 noisy go", 1'b1);

      // R2 again after passes: result held, nothing issued
      fill(1);
      begin
         bit quiet = 1'b1;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_en || done || sad != prev_result) quiet = 1'b0;
         end
         check(quiet, "R2 idle holds result", sad, prev_result);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(100000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule